// File: doc/BRIEF.md
# Decoupled Store-Address Check Queue

This block sits between the address-generating integer pipeline and the floating-point data pipeline of a decoupled access/execute core. The address side may run well ahead of the data side, taking loop branches while data work for earlier iterations is still pending. Each store's address is queued as soon as the address side produces it. The store data is supplied later by the data pipeline. A store is released to memory, address and data together, only when both halves are present at the head of the queue.

Every load address the address side wants to issue is compared, in the same cycle, against all store addresses still in the queue. A match raises a hazard flag so the load is held back. A second, independent FIFO holds returned load data as pending writebacks to data registers. The data pipeline drains it in program order. Entries are never merged by destination register, so several pending writes to one register may be queued at once.

Top module: `decoupled_mem_queue`

## Requirements
- R1: A synchronous active-high reset empties both queues. After reset `saqEmpty` and `ldqEmpty` are 1, `saqFull`, `ldqFull`, `memStValid` and `wbValid` are 0, and `saReady` and `ldRetReady` are 1.
- R2: A store address is accepted when `saValid` and `saReady` are both high. `saReady` is high only while fewer than 8 stores are pending. `saqFull` is high at 8 pending stores. An address offered while the queue is full is dropped and never reaches memory.
- R3: Store data is attached in order, to the oldest pending store that has no data yet. `sdReady` is high only while some pending store lacks data, so data offered to an empty queue, or while every pending store already has data, is dropped.
- R4: `memStValid` is high exactly when the oldest pending store has its data. Stores leave in the order their addresses arrived, carrying the full address as it was enqueued together with its attached data. A store that is not accepted keeps the same address on `memStAddr` in the next cycle.
- R5: `ldHazard` is high exactly when `ldCheckValid` is high and some pending store address equals `ldCheckAddr` in bits 63 to 3. Bits 2 to 0 are ignored in this comparison. A store released in the same cycle still counts as pending. A store address being enqueued in the same cycle does not count.
- R6: Returned load data (`ldRetReg`, `ldRetData`) is queued when `ldRetValid` and `ldRetReady` are both high. It is presented on `wbReg`/`wbData` in arrival order with `wbValid`, and is removed when `wbReady` is high. Entries with the same register are all kept.
- R7: The load-data queue holds 8 entries. `ldqFull` is set at 8 and `ldqEmpty` at 0. `ldRetReady` is low while full, even in a cycle that also pops. A return offered while the queue is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| saValid | input | 1 | Store address offered |
| saAddr | input | 64 | Store address |
| saReady | output | 1 | Store address queue can accept |
| sdValid | input | 1 | Store data offered by data pipeline |
| sdData | input | 64 | Store data |
| sdReady | output | 1 | A pending store is waiting for data |
| memStValid | output | 1 | Complete store at head, offered to memory |
| memStAddr | output | 64 | Released store address |
| memStData | output | 64 | Released store data |
| memStReady | input | 1 | Memory accepts the store |
| ldCheckValid | input | 1 | Load address to check |
| ldCheckAddr | input | 64 | Load address |
| ldHazard | output | 1 | Load matches a pending store |
| ldRetValid | input | 1 | Returned load data offered |
| ldRetReg | input | 5 | Destination data register |
| ldRetData | input | 64 | Returned load data |
| ldRetReady | output | 1 | Load-data queue can accept |
| wbValid | output | 1 | Pending writeback at head |
| wbReg | output | 5 | Head writeback register |
| wbData | output | 64 | Head writeback data |
| wbReady | input | 1 | Data pipeline takes the writeback |
| saqFull | output | 1 | Store address queue full |
| saqEmpty | output | 1 | Store address queue empty |
| ldqFull | output | 1 | Load-data queue full |
| ldqEmpty | output | 1 | Load-data queue empty |

## Verification
The case that most needs checking is a hazard check that lands in the same cycle as the release of the store it matches. The bench provokes it by draining the store queue with memory accepting stores on most cycles, while presenting the current head address as the load address. The hazard must still be raised in the release cycle, and it must drop once only non-matching entries remain. A long mixed phase then overlaps address pushes, data attachment, release, hazard checks and load-data traffic, using addresses drawn from a narrow window. Every output is compared each cycle against a queue model kept in the bench.

// File: rtl/dmq_pkg.sv
package dmq_pkg;
  // handshake strobes from control to datapath for one cycle
  typedef struct packed {
    logic saPush;   // store address written at tail
    logic sdWrite;  // store data written at data pointer
    logic stPop;    // head store released to memory
    logic lqPush;   // load return written at tail
    logic lqPop;    // writeback head consumed
  } qStrobe_t;
endpackage

// File: rtl/dmq_ctrl.sv
module dmq_ctrl
  import dmq_pkg::*;
#(
  parameter int SQ_DEPTH = 8,
  parameter int LQ_DEPTH = 8,
  localparam int SQ_PW = $clog2(SQ_DEPTH),
  localparam int LQ_PW = $clog2(LQ_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               saValid,
  input  logic               sdValid,
  input  logic               memStReady,
  input  logic               ldRetValid,
  input  logic               wbReady,
  output logic               saReady,
  output logic               sdReady,
  output logic               memStValid,
  output logic               ldRetReady,
  output logic               wbValid,
  output logic               saqFull,
  output logic               saqEmpty,
  output logic               ldqFull,
  output logic               ldqEmpty,
  output qStrobe_t           strobe,
  output logic [SQ_PW-1:0]   saHead,
  output logic [SQ_PW-1:0]   saTail,
  output logic [SQ_PW-1:0]   sdPtr,
  output logic [LQ_PW-1:0]   lqHead,
  output logic [LQ_PW-1:0]   lqTail,
  output logic [SQ_DEPTH-1:0] saLive
);
  localparam int SQ_CW = SQ_PW + 1;
  localparam int LQ_CW = LQ_PW + 1;
  localparam logic [SQ_CW-1:0] SQ_FULL = SQ_CW'(SQ_DEPTH);
  localparam logic [LQ_CW-1:0] LQ_FULL = LQ_CW'(LQ_DEPTH);

  logic [SQ_CW-1:0] saCnt;   // stores holding an address
  logic [SQ_CW-1:0] sdCnt;   // of those, stores that also hold data
  logic [LQ_CW-1:0] lqCnt;

  assign saqFull    = (saCnt == SQ_FULL);
  assign saqEmpty   = (saCnt == '0);
  assign ldqFull    = (lqCnt == LQ_FULL);
  assign ldqEmpty   = (lqCnt == '0);
  assign saReady    = !saqFull;
  assign sdReady    = (sdCnt < saCnt);
  assign memStValid = (sdCnt != '0);   // data attaches in order, so head has data
  assign ldRetReady = !ldqFull;
  assign wbValid    = !ldqEmpty;

  always_comb begin
    strobe.saPush  = saValid && saReady;
    strobe.sdWrite = sdValid && sdReady;
    strobe.stPop   = memStValid && memStReady;
    strobe.lqPush  = ldRetValid && ldRetReady;
    strobe.lqPop   = wbValid && wbReady;
  end

  // occupancy mask of the store ring, used by the hazard comparators
  for (genvar i = 0; i < SQ_DEPTH; i++) begin : g_live
    logic [SQ_PW-1:0] rel;
    assign rel       = SQ_PW'(i) - saHead;
    assign saLive[i] = ({1'b0, rel} < saCnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      saCnt  <= '0;
      sdCnt  <= '0;
      lqCnt  <= '0;
      saHead <= '0;
      saTail <= '0;
      sdPtr  <= '0;
      lqHead <= '0;
      lqTail <= '0;
    end else begin
      saCnt <= saCnt + SQ_CW'(strobe.saPush) - SQ_CW'(strobe.stPop);
      sdCnt <= sdCnt + SQ_CW'(strobe.sdWrite) - SQ_CW'(strobe.stPop);
      lqCnt <= lqCnt + LQ_CW'(strobe.lqPush) - LQ_CW'(strobe.lqPop);
      if (strobe.saPush)  saTail <= saTail + SQ_PW'(1);
      if (strobe.sdWrite) sdPtr  <= sdPtr  + SQ_PW'(1);
      if (strobe.stPop)   saHead <= saHead + SQ_PW'(1);
      if (strobe.lqPush)  lqTail <= lqTail + LQ_PW'(1);
      if (strobe.lqPop)   lqHead <= lqHead + LQ_PW'(1);
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    saqFull |=> !(saCnt > SQ_FULL));

  // R3
  data_order_chk: assert property (@(posedge clk) disable iff (rst)
    !(sdCnt > saCnt));

  // R4
  st_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memStValid && !memStReady) |=> memStValid);

  // R7
  lq_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ldqFull && !wbReady) |=> (ldqFull && !ldRetReady));
endmodule

// File: rtl/dmq_data.sv
module dmq_data
  import dmq_pkg::*;
#(
  parameter int AW = 64,
  parameter int DW = 64,
  parameter int RW = 5,
  parameter int OFS_BITS = 3,
  parameter int SQ_DEPTH = 8,
  parameter int LQ_DEPTH = 8,
  localparam int SQ_PW = $clog2(SQ_DEPTH),
  localparam int LQ_PW = $clog2(LQ_DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  qStrobe_t            strobe,
  input  logic [SQ_PW-1:0]    saHead,
  input  logic [SQ_PW-1:0]    saTail,
  input  logic [SQ_PW-1:0]    sdPtr,
  input  logic [LQ_PW-1:0]    lqHead,
  input  logic [LQ_PW-1:0]    lqTail,
  input  logic [SQ_DEPTH-1:0] saLive,
  input  logic [AW-1:0]       saAddr,
  input  logic [DW-1:0]       sdData,
  input  logic                ldCheckValid,
  input  logic [AW-1:0]       ldCheckAddr,
  input  logic [RW-1:0]       ldRetReg,
  input  logic [DW-1:0]       ldRetData,
  output logic [AW-1:0]       memStAddr,
  output logic [DW-1:0]       memStData,
  output logic                ldHazard,
  output logic [RW-1:0]       wbReg,
  output logic [DW-1:0]       wbData
);
  localparam logic [AW-1:0] ALIGN_MASK = {AW{1'b1}} << OFS_BITS;

  logic [AW-1:0] addrMem [SQ_DEPTH];
  logic [DW-1:0] dataMem [SQ_DEPTH];
  logic [RW-1:0] regMem  [LQ_DEPTH];
  logic [DW-1:0] retMem  [LQ_DEPTH];
  logic [SQ_DEPTH-1:0] hit;

  always_ff @(posedge clk) begin
    if (strobe.saPush)  addrMem[saTail] <= saAddr;
    if (strobe.sdWrite) dataMem[sdPtr]  <= sdData;
    if (strobe.lqPush) begin
      regMem[lqTail] <= ldRetReg;
      retMem[lqTail] <= ldRetData;
    end
  end

  // one comparator per store slot, word granularity
  for (genvar i = 0; i < SQ_DEPTH; i++) begin : g_cmp
    assign hit[i] = saLive[i] &&
                    (((addrMem[i] ^ ldCheckAddr) & ALIGN_MASK) == '0);
  end

  assign ldHazard  = ldCheckValid && (|hit);
  assign memStAddr = addrMem[saHead];
  assign memStData = dataMem[saHead];
  assign wbReg     = regMem[lqHead];
  assign wbData    = retMem[lqHead];

  // R5
  hazard_live_chk: assert property (@(posedge clk) disable iff (rst)
    ldHazard |-> (ldCheckValid && (saLive != '0)));

  // R4
  head_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (saLive[saHead] && !strobe.stPop) |=> $stable(memStAddr));
endmodule

// File: rtl/decoupled_mem_queue.sv
module decoupled_mem_queue
  import dmq_pkg::*;
#(
  parameter int AW = 64,
  parameter int DW = 64,
  parameter int RW = 5,
  parameter int OFS_BITS = 3,
  parameter int SQ_DEPTH = 8,
  parameter int LQ_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          saValid,
  input  logic [AW-1:0] saAddr,
  output logic          saReady,
  input  logic          sdValid,
  input  logic [DW-1:0] sdData,
  output logic          sdReady,
  output logic          memStValid,
  output logic [AW-1:0] memStAddr,
  output logic [DW-1:0] memStData,
  input  logic          memStReady,
  input  logic          ldCheckValid,
  input  logic [AW-1:0] ldCheckAddr,
  output logic          ldHazard,
  input  logic          ldRetValid,
  input  logic [RW-1:0] ldRetReg,
  input  logic [DW-1:0] ldRetData,
  output logic          ldRetReady,
  output logic          wbValid,
  output logic [RW-1:0] wbReg,
  output logic [DW-1:0] wbData,
  input  logic          wbReady,
  output logic          saqFull,
  output logic          saqEmpty,
  output logic          ldqFull,
  output logic          ldqEmpty
);
  localparam int SQ_PW = $clog2(SQ_DEPTH);
  localparam int LQ_PW = $clog2(LQ_DEPTH);

  qStrobe_t            strobe;
  logic [SQ_PW-1:0]    saHead, saTail, sdPtr;
  logic [LQ_PW-1:0]    lqHead, lqTail;
  logic [SQ_DEPTH-1:0] saLive;

  dmq_ctrl #(.SQ_DEPTH(SQ_DEPTH), .LQ_DEPTH(LQ_DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .saValid(saValid), .sdValid(sdValid), .memStReady(memStReady),
    .ldRetValid(ldRetValid), .wbReady(wbReady),
    .saReady(saReady), .sdReady(sdReady), .memStValid(memStValid),
    .ldRetReady(ldRetReady), .wbValid(wbValid),
    .saqFull(saqFull), .saqEmpty(saqEmpty), .ldqFull(ldqFull), .ldqEmpty(ldqEmpty),
    .strobe(strobe), .saHead(saHead), .saTail(saTail), .sdPtr(sdPtr),
    .lqHead(lqHead), .lqTail(lqTail), .saLive(saLive)
  );

  dmq_data #(.AW(AW), .DW(DW), .RW(RW), .OFS_BITS(OFS_BITS),
             .SQ_DEPTH(SQ_DEPTH), .LQ_DEPTH(LQ_DEPTH)) u_data (
    .clk(clk), .rst(rst), .strobe(strobe),
    .saHead(saHead), .saTail(saTail), .sdPtr(sdPtr),
    .lqHead(lqHead), .lqTail(lqTail), .saLive(saLive),
    .saAddr(saAddr), .sdData(sdData),
    .ldCheckValid(ldCheckValid), .ldCheckAddr(ldCheckAddr),
    .ldRetReg(ldRetReg), .ldRetData(ldRetData),
    .memStAddr(memStAddr), .memStData(memStData), .ldHazard(ldHazard),
    .wbReg(wbReg), .wbData(wbData)
  );
endmodule

// File: tb/test_decoupled_mem_queue.sv
`timescale 1ns/1ps
module test_decoupled_mem_queue;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic saValid = 0, sdValid = 0, memStReady = 0, ldCheckValid = 0, ldRetValid = 0, wbReady = 0;
  logic [63:0] saAddr = '0, sdData = '0, ldCheckAddr = '0, ldRetData = '0;
  logic [4:0]  ldRetReg = '0;
  logic saReady, sdReady, memStValid, ldHazard, ldRetReady, wbValid;
  logic saqFull, saqEmpty, ldqFull, ldqEmpty;
  logic [63:0] memStAddr, memStData, wbData;
  logic [4:0]  wbReg;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [63:0] addrQ[$];
  logic [63:0] dataQ[$];
  logic [68:0] lq[$];

  always #2.5 clk = ~clk;

  decoupled_mem_queue i_decoupled_mem_queue (
    .clk(clk), .rst(rst),
    .saValid(saValid), .saAddr(saAddr), .saReady(saReady),
    .sdValid(sdValid), .sdData(sdData), .sdReady(sdReady),
    .memStValid(memStValid), .memStAddr(memStAddr), .memStData(memStData),
    .memStReady(memStReady),
    .ldCheckValid(ldCheckValid), .ldCheckAddr(ldCheckAddr), .ldHazard(ldHazard),
    .ldRetValid(ldRetValid), .ldRetReg(ldRetReg), .ldRetData(ldRetData),
    .ldRetReady(ldRetReady),
    .wbValid(wbValid), .wbReg(wbReg), .wbData(wbData), .wbReady(wbReady),
    .saqFull(saqFull), .saqEmpty(saqEmpty), .ldqFull(ldqFull), .ldqEmpty(ldqEmpty)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one clock cycle: drive at negedge, compare just after, update model at posedge
  task automatic cycle(bit sav, logic [63:0] saa, bit sdv, logic [63:0] sdd, bit msr,
                       bit lcv, logic [63:0] lca, bit lrv, logic [4:0] lrr,
                       logic [63:0] lrd, bit wbr);
    bit eSaR, eSdR, eMemV, eHaz, eLqR, eWbV;
    @(negedge clk);
    saValid = sav; saAddr = saa; sdValid = sdv; sdData = sdd; memStReady = msr;
    ldCheckValid = lcv; ldCheckAddr = lca; ldRetValid = lrv; ldRetReg = lrr;
    ldRetData = lrd; wbReady = wbr;
    #1;
    eSaR  = addrQ.size() < 8;
    eSdR  = dataQ.size() < addrQ.size();
    eMemV = dataQ.size() > 0;
    eLqR  = lq.size() < 8;
    eWbV  = lq.size() > 0;
    eHaz  = 0;
    foreach (addrQ[k]) if (lcv && (((addrQ[k] ^ lca) & ~64'h7) == 64'h0)) eHaz = 1;
    chk("R2", "saReady", 64'(saReady), 64'(eSaR));
    chk("R2", "saqFull", 64'(saqFull), 64'(addrQ.size() == 8));
    chk("R2", "saqEmpty", 64'(saqEmpty), 64'(addrQ.size() == 0));
    chk("R3", "sdReady", 64'(sdReady), 64'(eSdR));
    chk("R4", "memStValid", 64'(memStValid), 64'(eMemV));
    if (eMemV) begin
      chk("R4", "memStAddr", memStAddr, addrQ[0]);
      chk("R4", "memStData", memStData, dataQ[0]);
    end
    chk("R5", "ldHazard", 64'(ldHazard), 64'(eHaz));
    chk("R7", "ldRetReady", 64'(ldRetReady), 64'(eLqR));
    chk("R7", "ldqFull", 64'(ldqFull), 64'(lq.size() == 8));
    chk("R7", "ldqEmpty", 64'(ldqEmpty), 64'(lq.size() == 0));
    chk("R6", "wbValid", 64'(wbValid), 64'(eWbV));
    if (eWbV) begin
      chk("R6", "wbReg", 64'(wbReg), 64'(lq[0][68:64]));
      chk("R6", "wbData", wbData, lq[0][63:0]);
    end
    @(posedge clk);
    if (sav && eSaR) addrQ.push_back(saa);
    if (sdv && eSdR) dataQ.push_back(sdd);
    if (eMemV && msr) begin
      void'(addrQ.pop_front());
      void'(dataQ.pop_front());
    end
    if (lrv && eLqR) lq.push_back({lrr, lrd});
    if (eWbV && wbr) void'(lq.pop_front());
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1", "saqEmpty", 64'(saqEmpty), 64'd1);
    chk("R1", "ldqEmpty", 64'(ldqEmpty), 64'd1);
    chk("R1", "memStValid", 64'(memStValid), 64'd0);
    chk("R1", "wbValid", 64'(wbValid), 64'd0);
    chk("R1", "saReady", 64'(saReady), 64'd1);
    chk("R1", "ldRetReady", 64'(ldRetReady), 64'd1);
    idle();

    // R3: data offered to an empty store queue is dropped
    cycle(0, 0, 1, 64'hBAD0, 0, 0, 0, 0, 0, 0, 0);

    // R2: fill past capacity with low offset bits set; two pushes refused
    for (int i = 0; i < 10; i++)
      cycle(1, 64'h1000 + 64'(i) * 64 + 64'(i % 8), 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R5: word-granular compare against every slot, every byte offset, plus near misses
    for (int j = 0; j < 10; j++)
      for (int off = 0; off < 16; off++)
        cycle(0, 0, 0, 0, 0, 1, 64'h1000 + 64'(j) * 64 + 64'(off), 0, 0, 0, 0);

    // R3/R4/R5: attach data while releasing; hazard check aimed at the head being released
    for (int i = 0; i < 14; i++)
      cycle(0, 0, 1, 64'hD000 + 64'(i), (i % 3) != 0, 1,
            (addrQ.size() > 0) ? addrQ[0] : 64'h1000, 0, 0, 0, 0);
    idle();

    // R5: an address enqueued this cycle is not compared
    cycle(1, 64'h5008, 0, 0, 0, 1, 64'h5008, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 1, 64'h500F, 0, 0, 0, 0);
    // R4: hold while memory stalls, then release
    cycle(0, 0, 1, 64'hFEED, 0, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    idle();

    // R6/R7: same register repeatedly, overfill, then drain with concurrent returns
    for (int i = 0; i < 10; i++)
      cycle(0, 0, 0, 0, 0, 0, 0, 1, 5'd7, 64'hA000 + 64'(i), 0);
    for (int i = 0; i < 12; i++)
      cycle(0, 0, 0, 0, 0, 0, 0, (i % 2) == 0, 5'(i), 64'hB000 + 64'(i), 1);
    for (int i = 0; i < 6; i++) idle();

    // mixed traffic over a narrow address window
    for (int i = 0; i < 4000; i++) begin
      automatic logic [31:0] r = $urandom;
      cycle(r[0], 64'h2000 + 64'(r[7:4]) * 8 + 64'(r[10:8]), r[1], 64'(r[31:12]) + 64'(i),
            r[2] | r[3], r[11], 64'h2000 + 64'(r[19:16]) * 8 + 64'(r[22:20]),
            r[12], 5'(r[27:23]), 64'(i) * 3, r[13] | r[14]);
    end

    finishRun();
  end
endmodule